// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the processor side of one transfer on a bus whose low lines carry both address and data, and whose upper address lines also carry status. A client presents a request: address, write data, memory or I/O space, direction, a flag that enables the upper data byte, and a status code. The controller then steps through four T-states, T1 to T4. In T1 it puts the address out and pulses the address latch strobe. In T2 and T3 it drives the active-low read or write strobe and the data enable. It releases everything in T4.

A slow target stretches the cycle by holding the ready input low. The controller samples ready in the last clock of T2 and in every wait state it inserts between T2 and T3. On a read it stops driving the shared lines from T2 onward, so the target can drive them. It captures the returned data at the end of T3 and presents it in T4 with a one-clock done pulse. A new request is taken only while the controller is idle.

The block does not drive tri-state pins. It supplies an output-enable for the shared lines and leaves the pad cells to the chip level.

Top module: `mux_bus_cycle`

## Requirements
- R1: After reset the controller is idle: req_ready=1, done=0, ale=0, ad_oe=0, rd_n=wr_n=den_n=bhe_n=1, m_io=0, dtr=0, hi_out=0.
- R2: A request is taken only when req_valid=1 while req_ready=1. The next clock is T1: ale=1, ad_oe=1, ad_out=req_addr[DATA_W-1:0], req_ready=0. ale is high for exactly that one clock. req_valid and request fields presented while the controller is busy have no effect on the cycle in progress.
- R3: From T2 through T3, including any wait states, den_n=0. rd_n=0 on a read (req_write=0) and wr_n=0 on a write (req_write=1). The two strobes are never low together. On a write, ad_oe=1 and ad_out=req_wdata in those clocks.
- R4: On a read, ad_oe=0 from T2 through T4, so the shared lines float.
- R5: ready_in is sampled in the last clock of T2 and in each wait state. While it is 0, one further wait state follows, with the strobes held asserted. With N wait states, the strobes stay low for N+2 clocks.
- R6: On a read, ad_in is captured in the last clock of T3 and appears on rd_data in T4, with done=1 for that single clock. rd_data keeps its value until the next read capture, so a write cycle leaves it unchanged.
- R7: In T4, rd_n, wr_n and den_n are 1, and ale=0 and ad_oe=0. The clock after T4 is idle with req_ready=1. A cycle without waits spans T1..T4 in four clocks.
- R8: bhe_n equals the inverse of req_bhe from T1 through T3 and is 1 in T4 and in idle.
- R9: hi_out carries req_addr[ADDR_W-1:DATA_W] in T1 and req_status in T2 through T4. m_io holds req_mem (1 = memory) and dtr holds req_write (1 = transmit) from T1 through T4. All three are 0 when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bhe | input | 1 | 1 = enable upper data byte |
| req_status | input | ADDR_W-DATA_W | Status code shown on the upper lines after T1 |
| ready_in | input | 1 | Target ready; 0 inserts a wait state |
| ad_in | input | DATA_W | Value read back from the shared lines |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-clock pulse in T4 |
| ale | output | 1 | Address latch strobe, high in T1 |
| ad_out | output | DATA_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| hi_out | output | ADDR_W-DATA_W | Upper address in T1, status afterwards |
| m_io | output | 1 | Memory (1) or I/O (0) cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den_n | output | 1 | Active-low data buffer enable |
| dtr | output | 1 | Data direction, 1 = transmit |
| bhe_n | output | 1 | Active-low upper byte enable |

## Verification
The bench builds the block with ADDR_W=20 and DATA_W=16, which gives a 4-bit shared address/status field. This width lets every status code on the upper lines be told apart. The bench sweeps every combination of direction, memory/I/O space and byte-high enable, and for each one it runs zero to three wait states. That covers each state transition, including a wait state that repeats. Half of the cycles also present a conflicting request while the controller is busy. Read data is placed on ad_in only in T3, so a capture one clock early or late shows up as a mismatch.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;
endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm import mbc_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_mem,
    input  logic                     req_write,
    input  logic                     req_bhe,
    input  logic [ADDR_W-DATA_W-1:0] req_status,
    input  logic                     ready_in,
    output bus_state_e               state_q,
    output logic [ADDR_W-1:0]        lat_addr,
    output logic [DATA_W-1:0]        lat_wdata,
    output logic                     lat_mem,
    output logic                     lat_write,
    output logic                     lat_bhe,
    output logic [ADDR_W-DATA_W-1:0] lat_status
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        bus_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                mem;
        logic                write;
        logic                bhe;
        logic [HI_W-1:0]     status;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_T1;
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.mem    = req_mem;
                    r_d.write  = req_write;
                    r_d.bhe    = req_bhe;
                    r_d.status = req_status;
                end
            end
            ST_T1:          r_d.st = ST_T2;
            ST_T2, ST_TW:   r_d.st = ready_in ? ST_T3 : ST_TW;
            ST_T3:          r_d.st = ST_T4;
            ST_T4:          r_d.st = ST_IDLE;
            default:        r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_q    = r_q.st;
    assign lat_addr   = r_q.addr;
    assign lat_wdata  = r_q.wdata;
    assign lat_mem    = r_q.mem;
    assign lat_write  = r_q.write;
    assign lat_bhe    = r_q.bhe;
    assign lat_status = r_q.status;

    // R5: a low ready in T2 or a wait state yields another wait state
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_T2 || r_q.st == ST_TW) && !ready_in) |=> (r_q.st == ST_TW));
    // R5: a high ready moves on to T3
    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_T2 || r_q.st == ST_TW) && ready_in) |=> (r_q.st == ST_T3));
    // R2: idle plus a request starts T1
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && req_valid) |=> (r_q.st == ST_T1));
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive import mbc_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  bus_state_e               state_q,
    input  logic [ADDR_W-1:0]        lat_addr,
    input  logic [DATA_W-1:0]        lat_wdata,
    input  logic                     lat_mem,
    input  logic                     lat_write,
    input  logic                     lat_bhe,
    input  logic [ADDR_W-DATA_W-1:0] lat_status,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     m_io,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dtr,
    output logic                     bhe_n,
    output logic                     done,
    output logic                     req_ready,
    output logic                     cap_en
);
    logic in_t1, strobe, active;

    always_comb begin
        in_t1  = (state_q == ST_T1);
        strobe = (state_q == ST_T2) || (state_q == ST_TW) || (state_q == ST_T3);
        active = (state_q != ST_IDLE);

        ale    = in_t1;
        ad_oe  = in_t1 || (strobe && lat_write);
        if (in_t1)                    ad_out = lat_addr[DATA_W-1:0];
        else if (strobe && lat_write) ad_out = lat_wdata;
        else                          ad_out = '0;

        if (in_t1)       hi_out = lat_addr[ADDR_W-1:DATA_W];
        else if (active) hi_out = lat_status;
        else             hi_out = '0;

        m_io      = active && lat_mem;
        dtr       = active && lat_write;
        rd_n      = !(strobe && !lat_write);
        wr_n      = !(strobe && lat_write);
        den_n     = !strobe;
        bhe_n     = !((in_t1 || strobe) && lat_bhe);
        done      = (state_q == ST_T4);
        req_ready = !active;
        cap_en    = (state_q == ST_T3) && !lat_write;
    end
endmodule

// File: rtl/mbc_capture.sv
module mbc_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (cap_en) c_d.data = ad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data = c_q.data;

    // R6: captured data holds between captures
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(c_q.data));
endmodule

// File: rtl/mux_bus_cycle.sv
module mux_bus_cycle import mbc_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_mem,
    input  logic                     req_write,
    input  logic                     req_bhe,
    input  logic [ADDR_W-DATA_W-1:0] req_status,
    input  logic                     ready_in,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     done,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     m_io,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dtr,
    output logic                     bhe_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_e        state_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_mem, lat_write, lat_bhe, cap_en;
    logic [HI_W-1:0]   lat_status;

    mbc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem),
        .req_write(req_write), .req_bhe(req_bhe), .req_status(req_status),
        .ready_in(ready_in), .state_q(state_q), .lat_addr(lat_addr),
        .lat_wdata(lat_wdata), .lat_mem(lat_mem), .lat_write(lat_write),
        .lat_bhe(lat_bhe), .lat_status(lat_status)
    );

    mbc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state_q(state_q), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
        .lat_mem(lat_mem), .lat_write(lat_write), .lat_bhe(lat_bhe),
        .lat_status(lat_status), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
        .hi_out(hi_out), .m_io(m_io), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .dtr(dtr), .bhe_n(bhe_n), .done(done),
        .req_ready(req_ready), .cap_en(cap_en)
    );

    mbc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .ad_in(ad_in),
        .rd_data(rd_data)
    );

    // R2: the address strobe lasts one clock
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R3: read and write strobes never overlap
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R4: shared lines released while the read strobe is low
    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R7: everything inactive in T4, idle afterwards
    p_t4_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && den_n && !ad_oe && !ale));
    p_t4_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));
endmodule

// File: tb/tb_mux_bus_cycle.sv
module tb_mux_bus_cycle;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int HI_W   = ADDR_W - DATA_W;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, req_mem, req_write, req_bhe, ready_in;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, ad_in, rd_data, ad_out;
    logic [HI_W-1:0]   req_status, hi_out;
    logic done, ale, ad_oe, m_io, rd_n, wr_n, den_n, dtr, bhe_n;

    int nchk = 0;
    int nfail = 0;
    logic [DATA_W-1:0] last_rd = '0;

    always #5 clk = ~clk;

    mux_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem),
        .req_write(req_write), .req_bhe(req_bhe), .req_status(req_status),
        .ready_in(ready_in), .ad_in(ad_in), .rd_data(rd_data), .done(done),
        .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
        .m_io(m_io), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr),
        .bhe_n(bhe_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input int idx, input logic w, input logic mem,
                             input logic bhe, input int nw);
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd, rdv;
        logic [HI_W-1:0]   st;
        addr = ADDR_W'((idx * 32'h1F3A7 + 32'h12345) & 32'hFFFFF);
        wd   = DATA_W'((idx * 32'h1357) ^ 32'hA5C3);
        rdv  = ~wd ^ DATA_W'(idx);
        st   = HI_W'(idx + 3);

        @(negedge clk);
        chk("R7 idle ready", {31'd0, req_ready}, 1);
        chk("R6 done idle", {31'd0, done}, 0);
        chk("R6 rd_data hold", {16'd0, rd_data}, {16'd0, last_rd});
        req_valid = 1'b1; req_addr = addr; req_wdata = wd; req_mem = mem;
        req_write = w; req_bhe = bhe; req_status = st; ready_in = 1'b0;
        ad_in = 16'hDEAD;

        @(negedge clk); // T1
        chk("R2 ale", {31'd0, ale}, 1);
        chk("R2 ad_oe", {31'd0, ad_oe}, 1);
        chk("R2 ad_out", {16'd0, ad_out}, {16'd0, addr[DATA_W-1:0]});
        chk("R2 busy", {31'd0, req_ready}, 0);
        chk("R9 hi addr", {28'd0, hi_out}, {28'd0, addr[ADDR_W-1:DATA_W]});
        chk("R9 m_io", {31'd0, m_io}, {31'd0, mem});
        chk("R9 dtr", {31'd0, dtr}, {31'd0, w});
        chk("R8 bhe_n T1", {31'd0, bhe_n}, {31'd0, !bhe});
        chk("R3 no strobe T1", {29'd0, rd_n, wr_n, den_n}, 7);
        if (idx[0]) begin
            req_valid = 1'b1; req_addr = ~addr; req_write = ~w;
            req_wdata = ~wd; req_status = ~st; req_bhe = ~bhe;
        end else begin
            req_valid = 1'b0;
        end

        @(negedge clk); // T2
        chk("R2 ale single", {31'd0, ale}, 0);
        chk("R3 rd_n T2", {31'd0, rd_n}, {31'd0, w});
        chk("R3 wr_n T2", {31'd0, wr_n}, {31'd0, !w});
        chk("R3 den_n T2", {31'd0, den_n}, 0);
        chk("R4 ad_oe T2", {31'd0, ad_oe}, {31'd0, w});
        if (w) chk("R3 wdata", {16'd0, ad_out}, {16'd0, wd});
        chk("R9 hi status", {28'd0, hi_out}, {28'd0, st});
        chk("R8 bhe_n T2", {31'd0, bhe_n}, {31'd0, !bhe});
        ready_in = (nw == 0);

        for (int k = 1; k <= nw; k++) begin
            @(negedge clk); // wait state
            chk("R5 strobe held", {30'd0, rd_n, wr_n}, w ? 32'd2 : 32'd1);
            chk("R5 den held", {31'd0, den_n}, 0);
            chk("R5 not done", {31'd0, done}, 0);
            chk("R4 ad_oe TW", {31'd0, ad_oe}, {31'd0, w});
            ready_in = (k == nw);
        end

        @(negedge clk); // T3
        chk("R5 strobe T3", {29'd0, rd_n, wr_n, den_n}, w ? 32'd4 : 32'd2);
        chk("R4 ad_oe T3", {31'd0, ad_oe}, {31'd0, w});
        chk("R6 not done T3", {31'd0, done}, 0);
        ad_in = rdv; ready_in = 1'b0;

        @(negedge clk); // T4
        ad_in = 16'hBEEF;
        chk("R6 done", {31'd0, done}, 1);
        if (!w) last_rd = rdv;
        chk("R6 rd_data", {16'd0, rd_data}, {16'd0, last_rd});
        chk("R7 quiet T4", {28'd0, rd_n, wr_n, den_n, ale}, 14);
        chk("R7 R4 ad_oe T4", {31'd0, ad_oe}, 0);
        chk("R8 bhe_n T4", {31'd0, bhe_n}, 1);
        chk("R9 hi T4", {28'd0, hi_out}, {28'd0, st});
        chk("R9 m_io T4", {31'd0, m_io}, {31'd0, mem});
        chk("R9 dtr T4", {31'd0, dtr}, {31'd0, w});
        req_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
        req_mem = 1'b0; req_write = 1'b0; req_bhe = 1'b0; req_status = '0;
        ready_in = 1'b0; ad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", {31'd0, req_ready}, 1);
        chk("R1 done ale oe", {29'd0, done, ale, ad_oe}, 0);
        chk("R1 strobes", {28'd0, rd_n, wr_n, den_n, bhe_n}, 15);
        chk("R1 m_io dtr hi", {26'd0, m_io, dtr, hi_out}, 0);

        begin
            int idx;
            idx = 0;
            for (int w = 0; w < 2; w++)
                for (int mem = 0; mem < 2; mem++)
                    for (int b = 0; b < 2; b++)
                        for (int nw = 0; nw < 4; nw++) begin
                            run_cycle(idx, w[0], mem[0], b[0], nw);
                            idx++;
                        end
        end

        @(negedge clk);
        chk("R7 final idle", {31'd0, req_ready}, 1);
        chk("R6 final hold", {16'd0, rd_data}, {16'd0, last_rd});
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule